// File: doc/BRIEF.md
# Programmable Interval Timer with One-Shot and Periodic Modes

This block is a down-counting interval timer that software controls through two memory-mapped words. A tick enable input, one pulse per microsecond in the intended system, paces the count. A control word written at the trigger address holds three fields: an enable flag, a mode flag and a reload value. When the count runs out, the timer raises a level interrupt that stays high until software acknowledges it at the status address.

The reload value is the number of ticks minus one. For example, a value of 0 fires after one tick and a value of N fires after N+1 ticks. In periodic mode the counter reloads on the expiring tick and keeps running. In one-shot mode the timer disables itself when it expires. Writing a word with the enable flag low stops a countdown in progress.

Both words can be read back. The status word reports the live count and the pending interrupt. The trigger word reports the stored mode and reload value together with the live enable flag.

Top module: `interval_timer`

## Requirements
- R1: After reset the interrupt is low, the timer is disabled, and both the trigger word (byte address 0x0) and the status word (byte address 0x4) read as zero.
- R2: A write to address 0x0 stores bit 31 as enable, bit 30 as mode and bits 28:0 as the reload value. When bit 31 is 1, the counter loads bits 28:0 at once and restarts, including when a countdown is already running. Reading 0x0 returns enable in bit 31, mode in bit 30, reload in bits 28:0, and zero in bit 29.
- R3: While enabled, the counter decrements by one on each cycle with tick high and holds on cycles with tick low. The timer expires on the tick that finds the count at zero, so a reload value V expires after V+1 ticks and V=0 expires after one tick.
- R4: In one-shot mode (bit 30 = 0), expiry clears the enable flag. The count stays at 0 and no further interrupt is raised until the trigger word is written again.
- R5: In periodic mode (bit 30 = 1), the counter loads the reload value on the expiring tick and keeps counting, raising the interrupt once per V+1 ticks.
- R6: Writing the trigger word with bit 31 = 0 disables the timer. The count then holds its value through later ticks and no interrupt is raised.
- R7: The interrupt output is active high and stays high until a write to address 0x4 has bit 30 = 1. A write to 0x4 with bit 30 = 0 leaves it unchanged.
- R8: If an expiry and a clearing write to 0x4 fall in the same cycle, the interrupt ends that cycle high.
- R9: Reading 0x4 returns the current count in bits 28:0 and the pending interrupt in bit 30. All other bits read 0.
- R10: Writes to addresses other than 0x0 and 0x4 change nothing, and reads from them return zero.
- R11: When a trigger write and a tick fall in the same cycle, the write takes priority: the counter holds the newly loaded value and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable, one pulse per timer tick |
| addr_i | input | ADDR_W (4) | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for addr_i |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
The bench builds the timer with READ_REG=0, so the read data follows the address in the same cycle. This lets it observe the live count on every clock and compare it against the reference model. The reload width stays at its full 29 bits and the ticks are supplied directly by the bench, so small reload values expire within a few cycles. The all-ones reload value is still exercised for its readback and field masking. Dense and sparse tick patterns bring the same-cycle corner cases within reach: a clear that meets an expiry, a trigger write that meets a tick, and a disable in mid-count.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

   typedef enum logic {
      IVT_ONESHOT  = 1'b0,
      IVT_PERIODIC = 1'b1
   } ivt_mode_e;

   typedef enum logic [1:0] {
      IVT_SEL_NONE = 2'd0,
      IVT_SEL_TRIG = 2'd1,
      IVT_SEL_STAT = 2'd2
   } ivt_sel_e;

endpackage

// File: rtl/ivt_regif.sv
module ivt_regif
   import ivt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int TRIG_OFS = 0,
   parameter int STAT_OFS = 4,
   parameter int CLR_BIT  = 30,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] trig_rb_i,
   input  logic [DATA_W-1:0] stat_rb_i,
   output logic              trig_wr_o,
   output logic              stat_clr_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int WORD_LSB = 2;
   localparam logic [ADDR_W-1:0] TRIG_A = ADDR_W'(TRIG_OFS);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

   if (ADDR_W <= WORD_LSB) begin : g_bad_addr_w
      $error("ivt_regif: ADDR_W must exceed the word offset bits");
   end
   if (TRIG_A[ADDR_W-1:WORD_LSB] == STAT_A[ADDR_W-1:WORD_LSB]) begin : g_bad_map
      $error("ivt_regif: trigger and status words overlap");
   end
   if (CLR_BIT >= DATA_W) begin : g_bad_clr
      $error("ivt_regif: clear bit outside data word");
   end

   ivt_sel_e sel;

   always_comb begin
      if (addr_i[ADDR_W-1:WORD_LSB] == TRIG_A[ADDR_W-1:WORD_LSB]) begin
         sel = IVT_SEL_TRIG;
      end else if (addr_i[ADDR_W-1:WORD_LSB] == STAT_A[ADDR_W-1:WORD_LSB]) begin
         sel = IVT_SEL_STAT;
      end else begin
         sel = IVT_SEL_NONE;
      end
   end

   assign trig_wr_o  = we_i && (sel == IVT_SEL_TRIG);
   assign stat_clr_o = we_i && (sel == IVT_SEL_STAT) && wdata_i[CLR_BIT];

   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      unique case (sel)
         IVT_SEL_TRIG: rd_mux = trig_rb_i;
         IVT_SEL_STAT: rd_mux = stat_rb_i;
         default:      rd_mux = '0;
      endcase
   end

   if (READ_REG) begin : g_rd_flop
      logic [DATA_W-1:0] rd_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_q <= '0;
         end else begin
            rd_q <= rd_mux;
         end
      end
      assign rdata_o = rd_q;
   end else begin : g_rd_comb
      assign rdata_o = rd_mux;
   end

endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int RELOAD_W = 29
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_i,
   input  logic                run_i,
   input  logic                periodic_i,
   input  logic                load_i,
   input  logic [RELOAD_W-1:0] load_val_i,
   input  logic [RELOAD_W-1:0] reload_i,
   output logic [RELOAD_W-1:0] cnt_o,
   output logic                expire_o
);

   if (RELOAD_W < 1) begin : g_bad_w
      $error("ivt_counter: RELOAD_W must be positive");
   end

   logic [RELOAD_W-1:0] cnt_q;
   logic                at_zero;
   logic                step;

   assign at_zero  = (cnt_q == '0);
   assign step     = run_i && tick_i && !load_i;
   assign expire_o = step && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (step) begin
         if (at_zero) begin
            if (periodic_i) begin
               cnt_q <= reload_i;
            end
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   assign cnt_o = cnt_q;

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && tick_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !load_i) |=> $stable(cnt_q));

   // R5
   periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expire_o && periodic_i) |=> (cnt_q == $past(reload_i)));

endmodule

// File: rtl/ivt_irq.sv
module ivt_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic irq_o
);

   logic irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (set_i) begin
         irq_q <= 1'b1;
      end else if (clr_i) begin
         irq_q <= 1'b0;
      end
   end

   assign irq_o = irq_q;

   // R8
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> irq_q);

   // R7
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clr_i) |=> irq_q);

endmodule

// File: rtl/interval_timer.sv
module interval_timer
   import ivt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int RELOAD_W = 29,
   parameter int TRIG_OFS = 0,
   parameter int STAT_OFS = 4,
   parameter bit READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              irq_o
);

   localparam int EN_BIT   = DATA_W - 1;
   localparam int MODE_BIT = DATA_W - 2;
   localparam int IRQ_BIT  = MODE_BIT;

   if (RELOAD_W > DATA_W - 3) begin : g_bad_fields
      $error("interval_timer: reload field collides with flag bits");
   end

   logic                trig_wr;
   logic                stat_clr;
   logic                en_q;
   ivt_mode_e           mode_q;
   logic [RELOAD_W-1:0] reload_q;
   logic [RELOAD_W-1:0] cnt;
   logic                cnt_expire;
   logic                irq;
   logic [DATA_W-1:0]   trig_rb;
   logic [DATA_W-1:0]   stat_rb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         mode_q   <= IVT_ONESHOT;
         reload_q <= '0;
      end else if (trig_wr) begin
         en_q     <= wdata_i[EN_BIT];
         mode_q   <= ivt_mode_e'(wdata_i[MODE_BIT]);
         reload_q <= wdata_i[RELOAD_W-1:0];
      end else if (cnt_expire && mode_q == IVT_ONESHOT) begin
         en_q     <= 1'b0;
      end
   end

   always_comb begin
      trig_rb                 = '0;
      trig_rb[EN_BIT]         = en_q;
      trig_rb[MODE_BIT]       = mode_q;
      trig_rb[RELOAD_W-1:0]   = reload_q;
      stat_rb                 = '0;
      stat_rb[IRQ_BIT]        = irq;
      stat_rb[RELOAD_W-1:0]   = cnt;
   end

   ivt_regif #(
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .TRIG_OFS (TRIG_OFS),
      .STAT_OFS (STAT_OFS),
      .CLR_BIT  (IRQ_BIT),
      .READ_REG (READ_REG)
   ) u_regif (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (addr_i),
      .we_i       (we_i),
      .wdata_i    (wdata_i),
      .trig_rb_i  (trig_rb),
      .stat_rb_i  (stat_rb),
      .trig_wr_o  (trig_wr),
      .stat_clr_o (stat_clr),
      .rdata_o    (rdata_o)
   );

   ivt_counter #(
      .RELOAD_W (RELOAD_W)
   ) u_counter (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .run_i      (en_q),
      .periodic_i (mode_q == IVT_PERIODIC),
      .load_i     (trig_wr && wdata_i[EN_BIT]),
      .load_val_i (wdata_i[RELOAD_W-1:0]),
      .reload_i   (reload_q),
      .cnt_o      (cnt),
      .expire_o   (cnt_expire)
   );

   ivt_irq u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (cnt_expire),
      .clr_i (stat_clr),
      .irq_o (irq)
   );

   assign irq_o = irq;

   // R4
   oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_expire && mode_q == IVT_ONESHOT) |=> !en_q);

   // R2
   trig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_wr && wdata_i[EN_BIT]) |=> (en_q && cnt == $past(wdata_i[RELOAD_W-1:0])));

endmodule

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [3:0]  addr = 4'h4;
   logic        we = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   string       cur_req = "R1";

   always #5 clk = ~clk;

   interval_timer #(
      .DATA_W (32), .ADDR_W (4), .RELOAD_W (29),
      .TRIG_OFS (0), .STAT_OFS (4), .READ_REG (1'b0)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .tick_i (tick), .addr_i (addr),
      .we_i (we), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq)
   );

   // behavioural reference model
   bit          m_en, m_mode, m_irq;
   int unsigned m_rel, m_cnt;

   function automatic logic [31:0] model_read(input logic [3:0] a);
      if (a[3:2] == 2'd0) return {m_en, m_mode, 1'b0, m_rel[28:0]};
      if (a[3:2] == 2'd1) return {1'b0, m_irq, 1'b0, m_cnt[28:0]};
      return 32'h0;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      bit expire;
      if (!rst_n) begin
         m_en = 0; m_mode = 0; m_irq = 0; m_rel = 0; m_cnt = 0;
      end else begin
         expire = m_en && tick && !(we && addr[3:2] == 2'd0) && m_cnt == 0;
         if (we && addr[3:2] == 2'd0) begin
            m_en = wdata[31]; m_mode = wdata[30]; m_rel = wdata[28:0];
            if (wdata[31]) m_cnt = wdata[28:0];
         end else if (m_en && tick) begin
            if (m_cnt == 0) begin
               if (m_mode) m_cnt = m_rel; else m_en = 0;
            end else begin
               m_cnt = m_cnt - 1;
            end
         end
         if (expire) m_irq = 1;
         else if (we && addr[3:2] == 2'd1 && wdata[30]) m_irq = 0;
      end
      #2;
      if (rst_n && !done) begin
         check({cur_req, " irq"}, {31'b0, irq}, {31'b0, m_irq});
         check({cur_req, " rdata"}, rdata, model_read(addr));
      end
   end

   task automatic drive(input bit w, input logic [3:0] a, input logic [31:0] d, input bit t);
      @(negedge clk);
      we = w; addr = a; wdata = d; tick = t;
   endtask

   task automatic idle(input int n, input int per);
      for (int k = 0; k < n; k++) drive(0, 4'h4, 32'h0, (k % per) == per - 1);
   endtask

   task automatic probe(input string req, input logic [3:0] a, input logic [31:0] exp_rd, input bit exp_irq);
      drive(0, a, 32'h0, 0);
      @(posedge clk); #3;
      check(req, rdata, exp_rd);
      check(req, {31'b0, irq}, {31'b0, exp_irq});
   endtask

   task automatic finish_up;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #2_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      cur_req = "R1";
      probe("R1 trig", 4'h0, 32'h0, 0);
      probe("R1 stat", 4'h4, 32'h0, 0);

      // R2 load and readback
      cur_req = "R2";
      drive(1, 4'h0, 32'h8000_0005, 0);
      probe("R2 trig", 4'h0, 32'h8000_0005, 0);
      probe("R2 stat", 4'h4, 32'h0000_0005, 0);

      // R3/R4 expiry after V+1 ticks, one-shot stop
      cur_req = "R3";
      idle(5, 1);
      probe("R3 before", 4'h4, 32'h0, 0);
      idle(1, 1);
      probe("R3 expire", 4'h4, 32'h4000_0000, 1);
      cur_req = "R4";
      idle(8, 1);
      probe("R4 stopped", 4'h0, 32'h0000_0005, 1);

      // R7 clear behaviour
      cur_req = "R7";
      drive(1, 4'h4, 32'hBFFF_FFFF, 0);
      probe("R7 no clear", 4'h4, 32'h4000_0000, 1);
      drive(1, 4'h4, 32'h4000_0000, 0);
      probe("R7 cleared", 4'h4, 32'h0, 0);

      // R3 value 0 expires after one tick
      cur_req = "R3";
      drive(1, 4'h0, 32'h8000_0000, 0);
      idle(1, 1);
      probe("R3 zero", 4'h4, 32'h4000_0000, 1);
      drive(1, 4'h4, 32'h4000_0000, 0);

      // R5 periodic, sparse ticks
      cur_req = "R5";
      drive(1, 4'h0, 32'hC000_0002, 0);
      idle(6, 2);
      probe("R5 first", 4'h4, 32'h4000_0002, 1);
      drive(1, 4'h4, 32'h4000_0000, 0);
      idle(4, 2);
      probe("R5 mid", 4'h4, 32'h0000_0000, 0);
      idle(2, 2);
      probe("R5 second", 4'h4, 32'h4000_0002, 1);
      idle(17, 3);

      // R8 clear meets expiry
      cur_req = "R8";
      drive(1, 4'h4, 32'h4000_0000, 0);
      drive(1, 4'h0, 32'hC000_0000, 0);
      drive(1, 4'h4, 32'h4000_0000, 1);
      @(posedge clk); #3;
      check("R8 irq kept", {31'b0, irq}, 32'h1);
      drive(1, 4'h4, 32'h4000_0000, 0);
      probe("R8 later clear", 4'h4, 32'h0, 0);

      // R6 disable mid count
      cur_req = "R6";
      drive(1, 4'h0, 32'h8000_0009, 0);
      idle(3, 1);
      drive(1, 4'h0, 32'h0, 0);
      idle(20, 1);
      probe("R6 held", 4'h4, 32'h0000_0006, 0);
      probe("R6 trig", 4'h0, 32'h0, 0);

      // R10 unmapped addresses
      cur_req = "R10";
      drive(1, 4'h8, 32'hC000_0003, 0);
      drive(1, 4'hC, 32'hFFFF_FFFF, 1);
      probe("R10 read 8", 4'h8, 32'h0, 0);
      probe("R10 trig", 4'h0, 32'h0, 0);
      probe("R10 stat", 4'h4, 32'h0000_0006, 0);

      // R11 write beats tick, and R2 restart while running
      cur_req = "R11";
      drive(1, 4'h0, 32'h8000_0004, 0);
      idle(2, 1);
      drive(1, 4'h0, 32'h8000_0007, 1);
      probe("R11 write wins", 4'h4, 32'h0000_0007, 0);
      idle(8, 1);
      probe("R11 expire", 4'h4, 32'h4000_0000, 1);
      drive(1, 4'h4, 32'h4000_0000, 0);

      // R9 full-scale readback and field masking
      cur_req = "R9";
      drive(1, 4'h0, 32'hFFFF_FFFF, 0);
      probe("R9 trig", 4'h0, 32'hDFFF_FFFF, 0);
      probe("R9 stat", 4'h4, 32'h1FFF_FFFF, 0);
      idle(3, 1);
      probe("R9 count", 4'h4, 32'h1FFF_FFFC, 0);

      idle(4, 1);
      finish_up();
   end

endmodule